// File: doc/BRIEF.md
# Shadow Store/Recall Power Sequencer

This block controls the copies between a volatile working memory and its nonvolatile shadow. Software asks for a store or a recall with one-cycle request pulses, which come from an address-sequence detector. Two digitized supply flags also drive the block. `supply_low` means the supply is below the switch threshold. `supply_dead` means it is below the lower reset threshold. A falling supply starts an automatic store, but only when the working memory holds unsaved writes. A supply that returns after having been below the reset level starts an automatic recall.

Each transfer runs as two timed phases. A store first erases the shadow and then programs it. A recall first clears the working memory and then copies the shadow into it, leaving the shadow unchanged. The arrays act on four phase strobes. While a transfer runs, the bus enables are withdrawn. At the end, a one-cycle completion pulse goes back to the sequence detector. Every duration is a parameter counted in clock cycles.

Top module: `nvs_sequencer`

## Requirements
- R1: After a synchronous reset the block is idle. `busy`, all four phase strobes and `done` are 0, `rd_en` and `wr_en` are 1, no recall is pending and no unsaved write is recorded.
- R2: In idle with the supply good and no recall pending, a `sw_store_req` sampled at a clock edge starts a store. `erase_ph` is high for STORE_CYC/2 cycles starting at the next edge. `program_ph` is then high for the remaining STORE_CYC-STORE_CYC/2 cycles. The store runs whether or not any write has occurred.
- R3: A `sw_recall_req` under the same conditions starts a recall. `clear_ph` is high for SWREC_CYC/2 cycles, then `copy_ph` is high for the rest of SWREC_CYC.
- R4: When the supply is low in idle (`supply_low` or `supply_dead` is 1) and an unsaved write exists, the block enters a grace window of GRACE_CYC cycles. In that window `wr_en` stays 1. An automatic store follows, with the same phases as R2.
- R5: When the supply is low in idle and no write has been accepted since the last completed transfer, no store runs. The block waits with `wr_en`=0 and `rd_en`=1 until the supply is good again.
- R6: A write is accepted when `wr_req` and `wr_en` are both 1. Each accepted write marks the memory as unsaved. The mark is cleared when any store or recall completes.
- R7: Any cycle with `supply_dead`=1 latches a pending recall. Once the block is idle with the supply good, the pending recall runs before any software request. It has a `clear_ph` phase of PUREC_CYC/2 cycles and a `copy_ph` phase of PUREC_CYC-PUREC_CYC/2 cycles.
- R8: A supply dip that sets `supply_low` but never `supply_dead` causes no recall on recovery.
- R9: While any phase strobe is high, `busy`=1 and both `rd_en` and `wr_en` are 0. `wr_en` is 0 whenever the block is neither idle nor in the grace window.
- R10: `done` is high for exactly one cycle, in the cycle right after the last cycle of a `program_ph` or `copy_ph` phase. At that point the block is idle again.
- R11: In idle the order of priority is: low supply, then pending recall, then software store, then software recall. Software requests that arrive while busy, in the grace window, or with a low supply are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| wr_req | input | 1 | Bus write strobe |
| supply_low | input | 1 | Supply below switch threshold |
| supply_dead | input | 1 | Supply below reset threshold |
| busy | output | 1 | A store or recall phase is active |
| rd_en | output | 1 | Bus reads allowed |
| wr_en | output | 1 | Bus writes allowed |
| erase_ph | output | 1 | Store phase 1: erase shadow |
| program_ph | output | 1 | Store phase 2: program shadow |
| clear_ph | output | 1 | Recall phase 1: clear working memory |
| copy_ph | output | 1 | Recall phase 2: copy shadow in |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with STORE_CYC=12, SWREC_CYC=6, PUREC_CYC=10 and GRACE_CYC=3. The real defaults run to millions of cycles. These short values bring every phase boundary, the grace window and the phase hand-offs within a few dozen cycles. Because the three recall and store lengths differ, a recall that takes the wrong length is visible at once. The short values also let the bench compare long chains in one run: a dip without a reset-level drop, a dip through the reset level, a clean power loss, and requests that collide with each other.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_GRACE = 3'd1,
    S_ERASE = 3'd2,
    S_PROG  = 3'd3,
    S_CLEAR = 3'd4,
    S_COPY  = 3'd5,
    S_DOWN  = 3'd6
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= len - 1'b1;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2: a loaded phase length is counted from len-1 down to zero
  a_r2_timer_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(len) - 1'b1));
  a_r2_timer_step: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/nvs_supply_mon.sv
module nvs_supply_mon (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic supply_dead,
  input  logic recall_go,
  output logic low_eff,
  output logic pend
);
  assign low_eff = supply_low | supply_dead;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (supply_dead) pend <= 1'b1;
    else if (recall_go) pend <= 1'b0;
  end

  // R7: reaching the reset level always leaves a recall pending
  a_r7_latch: assert property (@(posedge clk) disable iff (rst)
    supply_dead |=> pend);
  // R8: nothing but a reset-level drop creates a pending recall
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!supply_dead && !pend) |=> !pend);
endmodule

// File: rtl/nvs_dirty_flag.sv
module nvs_dirty_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end

  // R6: an accepted write marks memory unsaved; a completion clears it
  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> flag);
  a_r6_clr: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag);
endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer #(
  parameter int unsigned STORE_CYC = 2500000,
  parameter int unsigned SWREC_CYC = 5000,
  parameter int unsigned PUREC_CYC = 137500,
  parameter int unsigned GRACE_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic wr_req,
  input  logic supply_low,
  input  logic supply_dead,
  output logic busy,
  output logic rd_en,
  output logic wr_en,
  output logic erase_ph,
  output logic program_ph,
  output logic clear_ph,
  output logic copy_ph,
  output logic done
);
  import nvs_pkg::*;

  localparam int unsigned ERASE_LEN = STORE_CYC / 2;
  localparam int unsigned PROG_LEN  = STORE_CYC - ERASE_LEN;
  localparam int unsigned SWCLR_LEN = SWREC_CYC / 2;
  localparam int unsigned SWCPY_LEN = SWREC_CYC - SWCLR_LEN;
  localparam int unsigned PUCLR_LEN = PUREC_CYC / 2;
  localparam int unsigned PUCPY_LEN = PUREC_CYC - PUCLR_LEN;
  localparam int unsigned MAX_LEN   = max2(max2(STORE_CYC, SWREC_CYC), max2(PUREC_CYC, GRACE_CYC));
  localparam int CW = $clog2(MAX_LEN + 1);

  seq_state_t st, nxt;
  logic          rc_pu_q, rc_pu_d;
  logic          t_load, t_exp;
  logic [CW-1:0] t_len;
  logic          low_eff, pend, dirty;
  logic          recall_go, fin, wr_acc;

  assign wr_acc = wr_req & wr_en;

  nvs_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .len(t_len), .expired(t_exp)
  );

  nvs_supply_mon u_supply (
    .clk(clk), .rst(rst), .supply_low(supply_low), .supply_dead(supply_dead),
    .recall_go(recall_go), .low_eff(low_eff), .pend(pend)
  );

  nvs_dirty_flag u_dirty (
    .clk(clk), .rst(rst), .set(wr_acc), .clr(fin), .flag(dirty)
  );

  always_comb begin
    nxt       = st;
    t_load    = 1'b0;
    t_len     = '0;
    recall_go = 1'b0;
    fin       = 1'b0;
    rc_pu_d   = rc_pu_q;
    unique case (st)
      S_IDLE: begin
        if (low_eff) begin
          if (dirty || wr_acc) begin
            nxt = S_GRACE; t_load = 1'b1; t_len = CW'(GRACE_CYC);
          end else begin
            nxt = S_DOWN;
          end
        end else if (pend) begin
          nxt = S_CLEAR; t_load = 1'b1; t_len = CW'(PUCLR_LEN);
          recall_go = 1'b1; rc_pu_d = 1'b1;
        end else if (sw_store_req) begin
          nxt = S_ERASE; t_load = 1'b1; t_len = CW'(ERASE_LEN);
        end else if (sw_recall_req) begin
          nxt = S_CLEAR; t_load = 1'b1; t_len = CW'(SWCLR_LEN);
          rc_pu_d = 1'b0;
        end
      end
      S_GRACE: if (t_exp) begin
        nxt = S_ERASE; t_load = 1'b1; t_len = CW'(ERASE_LEN);
      end
      S_ERASE: if (t_exp) begin
        nxt = S_PROG; t_load = 1'b1; t_len = CW'(PROG_LEN);
      end
      S_PROG: if (t_exp) begin
        nxt = S_IDLE; fin = 1'b1;
      end
      S_CLEAR: if (t_exp) begin
        nxt = S_COPY; t_load = 1'b1;
        t_len = rc_pu_q ? CW'(PUCPY_LEN) : CW'(SWCPY_LEN);
      end
      S_COPY: if (t_exp) begin
        nxt = S_IDLE; fin = 1'b1;
      end
      S_DOWN: if (!low_eff) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      rc_pu_q    <= 1'b0;
      busy       <= 1'b0;
      rd_en      <= 1'b1;
      wr_en      <= 1'b1;
      erase_ph   <= 1'b0;
      program_ph <= 1'b0;
      clear_ph   <= 1'b0;
      copy_ph    <= 1'b0;
      done       <= 1'b0;
    end else begin
      st         <= nxt;
      rc_pu_q    <= rc_pu_d;
      busy       <= (nxt == S_ERASE) || (nxt == S_PROG) || (nxt == S_CLEAR) || (nxt == S_COPY);
      rd_en      <= !((nxt == S_ERASE) || (nxt == S_PROG) || (nxt == S_CLEAR) || (nxt == S_COPY));
      wr_en      <= (nxt == S_IDLE) || (nxt == S_GRACE);
      erase_ph   <= (nxt == S_ERASE);
      program_ph <= (nxt == S_PROG);
      clear_ph   <= (nxt == S_CLEAR);
      copy_ph    <= (nxt == S_COPY);
      done       <= fin;
    end
  end

  // R2: programming only ever follows erasing
  a_r2_order: assert property (@(posedge clk) disable iff (rst)
    $rose(program_ph) |-> $past(erase_ph));
  // R3: copying only ever follows clearing
  a_r3_order: assert property (@(posedge clk) disable iff (rst)
    $rose(copy_ph) |-> $past(clear_ph));
  // R9: bus locked out during any phase
  a_r9_lockout: assert property (@(posedge clk) disable iff (rst)
    (erase_ph || program_ph || clear_ph || copy_ph) |-> (busy && !rd_en && !wr_en));
  // R11: at most one phase strobe at a time
  a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_ph, program_ph, clear_ph, copy_ph}));
  // R10: completion is a single pulse right after a final phase
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_after: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(program_ph || copy_ph) && !busy));
  // R5: low supply with nothing unsaved never starts a store
  a_r5_skip: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && low_eff && !dirty && !wr_acc) |=> (!erase_ph && !wr_en));
endmodule

// File: tb/nvs_sequencer_test.sv
module nvs_sequencer_test;
  localparam int ST_C = 12, SW_C = 6, PU_C = 10, GR_C = 3;
  localparam int M_IDLE = 0, M_GRACE = 1, M_ERASE = 2, M_PROG = 3,
                 M_CLEAR = 4, M_COPY = 5, M_DOWN = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sw_store_req = 0, sw_recall_req = 0, wr_req = 0, supply_low = 0, supply_dead = 0;
  logic busy, rd_en, wr_en, erase_ph, program_ph, clear_ph, copy_ph, done;

  nvs_sequencer #(.STORE_CYC(ST_C), .SWREC_CYC(SW_C), .PUREC_CYC(PU_C), .GRACE_CYC(GR_C)) uut (
    .clk(clk), .rst(rst), .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
    .wr_req(wr_req), .supply_low(supply_low), .supply_dead(supply_dead),
    .busy(busy), .rd_en(rd_en), .wr_en(wr_en), .erase_ph(erase_ph), .program_ph(program_ph),
    .clear_ph(clear_ph), .copy_ph(copy_ph), .done(done)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference model
  int ms = M_IDLE, mc = 0;
  bit mdirty = 0, mpend = 0, mpu = 0, mdone = 0;

  always @(posedge clk) begin
    if (rst) begin
      ms = M_IDLE; mc = 0; mdirty = 0; mpend = 0; mpu = 0; mdone = 0;
    end else begin
      bit acc, lowe, fin, pclr;
      acc  = wr_req && (ms == M_IDLE || ms == M_GRACE);
      lowe = supply_low || supply_dead;
      fin  = 0; pclr = 0;
      if (ms == M_IDLE) begin
        if (lowe) begin
          if (mdirty || acc) begin ms = M_GRACE; mc = GR_C; end
          else ms = M_DOWN;
        end else if (mpend) begin
          ms = M_CLEAR; mc = PU_C / 2; mpu = 1; pclr = 1;
        end else if (sw_store_req) begin
          ms = M_ERASE; mc = ST_C / 2;
        end else if (sw_recall_req) begin
          ms = M_CLEAR; mc = SW_C / 2; mpu = 0;
        end
      end else if (ms == M_DOWN) begin
        if (!lowe) ms = M_IDLE;
      end else if (mc > 1) begin
        mc--;
      end else begin
        case (ms)
          M_GRACE: begin ms = M_ERASE; mc = ST_C / 2; end
          M_ERASE: begin ms = M_PROG; mc = ST_C - ST_C / 2; end
          M_CLEAR: begin ms = M_COPY; mc = mpu ? PU_C - PU_C / 2 : SW_C - SW_C / 2; end
          default: begin ms = M_IDLE; fin = 1; end
        endcase
      end
      if (fin) mdirty = 0; else if (acc) mdirty = 1;
      if (supply_dead) mpend = 1; else if (pclr) mpend = 0;
      mdone = fin;
    end
  end

  // observed phase counts
  int n_er = 0, n_pg = 0, n_cl = 0, n_cp = 0, n_dn = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [7:0] act, exp_v;
      bit b;
      b = (ms == M_ERASE || ms == M_PROG || ms == M_CLEAR || ms == M_COPY);
      act   = {busy, rd_en, wr_en, erase_ph, program_ph, clear_ph, copy_ph, done};
      exp_v = {b, !b, (ms == M_IDLE || ms == M_GRACE), ms == M_ERASE, ms == M_PROG,
               ms == M_CLEAR, ms == M_COPY, mdone};
      n_cmp++;
      if (act !== exp_v) begin
        n_bad++;
        $display("FAIL %s (R9 lockout/phase trace) t=%0t actual=%b expected=%b", cur_req, $time, act, exp_v);
      end
      n_er += erase_ph; n_pg += program_ph; n_cl += clear_ph; n_cp += copy_ph; n_dn += done;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input int act, input int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int e0, p0, c0, k0, d0;
    tick(3);
    // R1: reset state
    chk("R1 busy", busy, 0); chk("R1 rd_en", rd_en, 1); chk("R1 wr_en", wr_en, 1);
    chk("R1 strobes", {erase_ph, program_ph, clear_ph, copy_ph, done}, 0);
    rst = 0; tick(2);

    // R2: software store with no prior write still runs
    cur_req = "R2"; e0 = n_er; p0 = n_pg; d0 = n_dn;
    sw_store_req = 1; tick(); sw_store_req = 0;
    chk("R2 erase starts", erase_ph, 1);
    tick(14);
    chk("R2 erase cycles", n_er - e0, ST_C / 2);
    chk("R2 program cycles", n_pg - p0, ST_C - ST_C / 2);
    chk("R10 single done", n_dn - d0, 1);

    // R3 + R6: writes, then software recall clears the unsaved mark
    cur_req = "R3"; c0 = n_cl; k0 = n_cp;
    wr_req = 1; tick(2); wr_req = 0;
    sw_recall_req = 1; tick(); sw_recall_req = 0;
    tick(8);
    chk("R3 clear cycles", n_cl - c0, SW_C / 2);
    chk("R3 copy cycles", n_cp - k0, SW_C - SW_C / 2);

    // R5 + R6: clean power loss skips the store
    cur_req = "R5"; e0 = n_er;
    supply_low = 1; tick(5);
    chk("R5 wr_en locked", wr_en, 0);
    chk("R5 rd_en kept", rd_en, 1);
    // R11: software store ignored while supply low
    sw_store_req = 1; tick(); sw_store_req = 0; tick(2);
    chk("R6/R5 no store", n_er - e0, 0);
    chk("R11 ignored when low", n_er - e0, 0);
    supply_low = 0; tick(3);

    // R4: dirty power loss -> grace window with writes, then store
    cur_req = "R4"; e0 = n_er; p0 = n_pg;
    wr_req = 1; tick(); wr_req = 0;
    supply_low = 1; tick(2);
    chk("R4 grace wr_en", wr_en, 1);
    wr_req = 1; tick(); wr_req = 0;
    tick(20);
    chk("R4 erase cycles", n_er - e0, ST_C / 2);
    chk("R4 program cycles", n_pg - p0, ST_C - ST_C / 2);

    // R8: recovery without reset-level drop causes no recall
    cur_req = "R8"; c0 = n_cl;
    supply_low = 0; tick(15);
    chk("R8 no recall", n_cl - c0, 0);

    // R7: reset-level drop then recovery -> power-up recall length
    cur_req = "R7"; c0 = n_cl; k0 = n_cp;
    supply_low = 1; supply_dead = 1; tick(3);
    supply_dead = 0; tick(2);
    supply_low = 0;
    // R11: pending recall wins over a simultaneous software store
    sw_store_req = 1; tick(); sw_store_req = 0;
    tick(16);
    chk("R7 clear cycles", n_cl - c0, PU_C / 2);
    chk("R7 copy cycles", n_cp - k0, PU_C - PU_C / 2);

    // R11: store beats recall; requests while busy ignored
    cur_req = "R11"; e0 = n_er; c0 = n_cl;
    sw_store_req = 1; sw_recall_req = 1; tick(); sw_store_req = 0; sw_recall_req = 0;
    tick(3);
    sw_recall_req = 1; tick(); sw_recall_req = 0;
    tick(14);
    chk("R11 store first", n_er - e0, ST_C / 2);
    chk("R11 busy ignores", n_cl - c0, 0);
    chk("R9 idle rd_en", rd_en, 1);

    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule